// File: doc/BRIEF.md
# DMA Request Source Selector with Capture

This block is the request front end for a set of DMA channels. Each channel holds a 4-bit source code that picks one line from a shared bus of peripheral event inputs. The following lines are on that bus: serial receive and transmit interrupts, two external interrupts, two endpoint IN-ready flags, two endpoint OUT-ready flags, an OUT-FIFO-not-empty flag, a serial I/O interrupt and a timer interrupt. Every line passes through a two-flop synchroniser and an edge detector. The source code decides which edge counts. An event on the selected line sets that channel's capture flop. The flop stays set until the transfer engine acknowledges the request or software issues a capture clear.

Software programs each channel with one 7-bit write word. The word holds the source code, an enable bit and two command bits. The commands are a software trigger and a capture clear. Both act only during the write and always read back as zero. The request output of a channel is its capture flop gated by its enable. Software should issue the capture clear in the same write that sets the enable, so that an event captured while the channel was off does not start a transfer.

Top module: `dmarq_src_select`

## Requirements
- R1: On channel 0 the write-word source codes map to event lines as follows, all detected on the rising edge: 0001 serial receive (evt_i bit 0), 0010 serial transmit (bit 1), 0100 external interrupt 0 (bit 2), 1000 endpoint 1 OUT-ready (bit 6), 1001 endpoint 1 OUT-FIFO-not-empty (bit 7), 1010 endpoint 2 OUT-ready (bit 8), 1110 serial I/O (bit 9).
- R2: On every channel other than 0, codes 0001 and 0010 are unused, code 0100 selects external interrupt 1 (bit 3), and code 1110 selects the timer (bit 10). Codes 0000, 0011, 0111, 1011, 1100, 1101 and 1111 are unused on all channels. An unused code never sets the capture.
- R3: Codes 0101 (endpoint 1 IN-ready, bit 4) and 0110 (endpoint 2 IN-ready, bit 5) detect only the falling edge. The rising-edge codes ignore a falling edge.
- R4: A change on an event line sets the capture at the third rising clock edge after the change. This allows two edges for synchronisation and one for the edge detector.
- R5: A set capture holds until eng_ack for that channel is high at a clock edge. The capture is then clear after that edge.
- R6: If a new selected edge or a software trigger falls in the same cycle as an acknowledge or a capture clear, the capture is set after that edge.
- R7: A write with bit 4 (software trigger) set sets the capture at that write's clock edge. Bit 4 reads back as 0.
- R8: A write with bit 5 (capture clear) set clears the capture. Bit 5 reads back as 0. The source code (bits 3:0) and the enable (bit 6) read back as last written.
- R9: req_o of a channel equals its capture ANDed with its enable (bit 6). Events are captured while the channel is disabled. Enabling without a clear exposes such an event, and enabling together with a clear removes it.
- R10: A synchronous reset clears the captures, codes, enables and synchroniser flops, so req_o and cfg_rdata are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 11 | Raw asynchronous peripheral event lines |
| cfg_we | input | NUM_CH | Per-channel write strobe for cfg_wdata |
| cfg_wdata | input | 7 | Write word: [3:0] source code, [4] trigger, [5] capture clear, [6] enable |
| eng_ack | input | NUM_CH | Transfer engine has taken the channel's request |
| cfg_rdata | output | 7*NUM_CH | Per-channel readback, 7 bits per channel |
| req_o | output | NUM_CH | Per-channel transfer request |

## Verification
The capture flop has both set causes (a selected edge and a software trigger) and both clear causes (an engine acknowledge and a software capture clear). These causes can land on the same clock edge. Directed cases time the capture-clear write and the acknowledge pulse so that each meets the edge leaving the synchroniser. They also issue a trigger and a clear in one write, and each case expects the request to stay high. A random phase then mixes line toggles, writes and acknowledges every cycle. The bench compares each output against a cycle model in which set always beats clear.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

  localparam int EVT_W  = 11;
  localparam int IDX_W  = $clog2(EVT_W);
  localparam int CFG_W  = 7;

  // write-word field positions
  localparam int F_SEL_LSB = 0;
  localparam int F_TRIG    = 4;
  localparam int F_CLR     = 5;
  localparam int F_EN      = 6;

  // event bus line numbers
  localparam logic [IDX_W-1:0] EV_SER_RX  = 4'd0;
  localparam logic [IDX_W-1:0] EV_SER_TX  = 4'd1;
  localparam logic [IDX_W-1:0] EV_EXT0    = 4'd2;
  localparam logic [IDX_W-1:0] EV_EXT1    = 4'd3;
  localparam logic [IDX_W-1:0] EV_EP1_IN  = 4'd4;
  localparam logic [IDX_W-1:0] EV_EP2_IN  = 4'd5;
  localparam logic [IDX_W-1:0] EV_EP1_OUT = 4'd6;
  localparam logic [IDX_W-1:0] EV_EP1_NE  = 4'd7;
  localparam logic [IDX_W-1:0] EV_EP2_OUT = 4'd8;
  localparam logic [IDX_W-1:0] EV_SIO     = 4'd9;
  localparam logic [IDX_W-1:0] EV_TMR     = 4'd10;

  typedef enum logic [1:0] {DET_NONE, DET_RISE, DET_FALL} det_e;

  typedef struct packed {
    det_e             det;
    logic [IDX_W-1:0] idx;
  } route_t;

  // Source code to (event line, edge). Channel 0 has its own table; all
  // further channels share the second one.
  function automatic route_t route_of(input int ch, input logic [3:0] code);
    route_t r;
    r.det = DET_NONE;
    r.idx = '0;
    case (code)
      4'b0001: if (ch == 0) begin r.det = DET_RISE; r.idx = EV_SER_RX; end
      4'b0010: if (ch == 0) begin r.det = DET_RISE; r.idx = EV_SER_TX; end
      4'b0100: begin
        r.det = DET_RISE;
        r.idx = (ch == 0) ? EV_EXT0 : EV_EXT1;
      end
      4'b0101: begin r.det = DET_FALL; r.idx = EV_EP1_IN;  end
      4'b0110: begin r.det = DET_FALL; r.idx = EV_EP2_IN;  end
      4'b1000: begin r.det = DET_RISE; r.idx = EV_EP1_OUT; end
      4'b1001: begin r.det = DET_RISE; r.idx = EV_EP1_NE;  end
      4'b1010: begin r.det = DET_RISE; r.idx = EV_EP2_OUT; end
      4'b1110: begin
        r.det = DET_RISE;
        r.idx = (ch == 0) ? EV_SIO : EV_TMR;
      end
      default: begin r.det = DET_NONE; r.idx = '0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dmarq_edge_det.sv
module dmarq_edge_det #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  // one synchroniser chain per line, with one extra flop holding the
  // previous synchronised value
  for (genvar i = 0; i < W; i++) begin : g_line
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], raw[i]};
    end

    assign rise[i] =  chain[STAGES-1] & ~chain[STAGES];
    assign fall[i] = ~chain[STAGES-1] &  chain[STAGES];
  end

endmodule

// File: rtl/dmarq_chan_cfg.sv
module dmarq_chan_cfg
  import dmarq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [3:0]       sel,
  output logic             en,
  output logic             trig,
  output logic             clr,
  output logic [CFG_W-1:0] rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
      en  <= 1'b0;
    end else if (we) begin
      sel <= wdata[F_SEL_LSB +: 4];
      en  <= wdata[F_EN];
    end
  end

  // command bits act only during the write; nothing is stored
  assign trig = we & wdata[F_TRIG];
  assign clr  = we & wdata[F_CLR];

  always_comb begin
    rdata                  = '0;
    rdata[F_SEL_LSB +: 4]  = sel;
    rdata[F_EN]            = en;
  end

endmodule

// File: rtl/dmarq_capture.sv
module dmarq_capture
  import dmarq_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       sel,
  input  logic             en,
  input  logic [EVT_W-1:0] rise,
  input  logic [EVT_W-1:0] fall,
  input  logic             trig,
  input  logic             clr,
  input  logic             ack,
  output logic             hit,
  output logic             cap,
  output logic             req
);

  route_t rt;

  always_comb begin
    rt = route_of(CH, sel);
    case (rt.det)
      DET_RISE: hit = rise[rt.idx];
      DET_FALL: hit = fall[rt.idx];
      default:  hit = 1'b0;
    endcase
  end

  // set has priority over both clear causes
  always_ff @(posedge clk) begin
    if (rst)              cap <= 1'b0;
    else if (hit || trig) cap <= 1'b1;
    else if (clr || ack)  cap <= 1'b0;
  end

  assign req = cap & en;

endmodule

// File: rtl/dmarq_src_select.sv
module dmarq_src_select
  import dmarq_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [EVT_W-1:0]        evt_i,
  input  logic [NUM_CH-1:0]       cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  input  logic [NUM_CH-1:0]       eng_ack,
  output logic [NUM_CH*CFG_W-1:0] cfg_rdata,
  output logic [NUM_CH-1:0]       req_o
);

  logic [EVT_W-1:0]  rise, fall;
  logic [NUM_CH-1:0] cap_vec, hit_vec;

  dmarq_edge_det #(.W(EVT_W), .STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .raw  (evt_i),
    .rise (rise),
    .fall (fall)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [3:0] sel;
    logic       en, trig, clr;

    dmarq_chan_cfg u_cfg (
      .clk   (clk),
      .rst   (rst),
      .we    (cfg_we[c]),
      .wdata (cfg_wdata),
      .sel   (sel),
      .en    (en),
      .trig  (trig),
      .clr   (clr),
      .rdata (cfg_rdata[c*CFG_W +: CFG_W])
    );

    dmarq_capture #(.CH(c)) u_cap (
      .clk  (clk),
      .rst  (rst),
      .sel  (sel),
      .en   (en),
      .rise (rise),
      .fall (fall),
      .trig (trig),
      .clr  (clr),
      .ack  (eng_ack[c]),
      .hit  (hit_vec[c]),
      .cap  (cap_vec[c]),
      .req  (req_o[c])
    );
  end

endmodule

// File: rtl/dmarq_chk.sv
module dmarq_chk
  import dmarq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_CH-1:0]       cfg_we,
  input logic [CFG_W-1:0]        cfg_wdata,
  input logic [NUM_CH-1:0]       eng_ack,
  input logic [NUM_CH*CFG_W-1:0] cfg_rdata,
  input logic [NUM_CH-1:0]       req_o,
  input logic [NUM_CH-1:0]       cap_vec,
  input logic [NUM_CH-1:0]       hit_vec
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam int B = c * CFG_W;

    // R9
    req_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
      req_o[c] |-> cfg_rdata[B + F_EN]);

    // R9
    req_follows_cap_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_vec[c] && cfg_rdata[B + F_EN]) |-> req_o[c]);

    // R7
    trig_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_rdata[B + F_TRIG]);

    // R8
    clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !cfg_rdata[B + F_CLR]);

    // R8
    readback_chk: assert property (@(posedge clk) disable iff (rst)
      cfg_we[c] |=> (cfg_rdata[B +: 4] == $past(cfg_wdata[3:0]))
                    && (cfg_rdata[B + F_EN] == $past(cfg_wdata[F_EN])));

    // R6
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
      hit_vec[c] |=> cap_vec[c]);

    // R7
    trig_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_we[c] && cfg_wdata[F_TRIG]) |=> cap_vec[c]);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (eng_ack[c] && !hit_vec[c] && !(cfg_we[c] && cfg_wdata[F_TRIG]))
        |=> !cap_vec[c]);

    // R8
    clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (cfg_we[c] && cfg_wdata[F_CLR] && !cfg_wdata[F_TRIG] && !hit_vec[c])
        |=> !cap_vec[c]);

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (cap_vec[c] && !eng_ack[c] && !(cfg_we[c] && cfg_wdata[F_CLR]))
        |=> cap_vec[c]);

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
      (!hit_vec[c] && !(cfg_we[c] && cfg_wdata[F_TRIG])) |=> !$rose(cap_vec[c]));
  end

endmodule

bind dmarq_src_select dmarq_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .eng_ack   (eng_ack),
  .cfg_rdata (cfg_rdata),
  .req_o     (req_o),
  .cap_vec   (cap_vec),
  .hit_vec   (hit_vec)
);

// File: tb/dmarq_src_select_tb.sv
`timescale 1ns/1ps
module dmarq_src_select_tb;

  localparam int NCH = 2;
  localparam int EW  = 11;
  localparam int CW  = 7;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [EW-1:0]     evt = '0;
  logic [NCH-1:0]    we  = '0;
  logic [CW-1:0]     wd  = '0;
  logic [NCH-1:0]    ack = '0;
  logic [NCH*CW-1:0] rdata;
  logic [NCH-1:0]    req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  dmarq_src_select #(.NUM_CH(NCH), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .evt_i(evt), .cfg_we(we), .cfg_wdata(wd),
    .eng_ack(ack), .cfg_rdata(rdata), .req_o(req)
  );

  // ---- reference: source table from R1..R3, kind 0 none, 1 rise, 2 fall
  function automatic void tb_src(input int ch, input int code,
                                 output int idx, output int kind);
    idx = 0; kind = 0;
    case (code)
      1:  if (ch == 0) begin idx = 0; kind = 1; end
      2:  if (ch == 0) begin idx = 1; kind = 1; end
      4:  begin idx = (ch == 0) ? 2 : 3; kind = 1; end
      5:  begin idx = 4; kind = 2; end
      6:  begin idx = 5; kind = 2; end
      8:  begin idx = 6; kind = 1; end
      9:  begin idx = 7; kind = 1; end
      10: begin idx = 8; kind = 1; end
      14: begin idx = (ch == 0) ? 9 : 10; kind = 1; end
      default: kind = 0;
    endcase
  endfunction

  // ---- cycle model
  logic [EW-1:0]  m_s1 = '0, m_s2 = '0, m_s3 = '0;
  logic [NCH-1:0] m_cap = '0, m_en = '0;
  logic [3:0]     m_sel [NCH];

  initial for (int c = 0; c < NCH; c++) m_sel[c] = '0;

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_cap = '0; m_en = '0;
      for (int c = 0; c < NCH; c++) m_sel[c] = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int idx, kind;
        bit hit, setv, clrv;
        tb_src(c, int'(m_sel[c]), idx, kind);
        hit  = (kind == 1) ? (m_s2[idx] & ~m_s3[idx]) :
               (kind == 2) ? (~m_s2[idx] & m_s3[idx]) : 1'b0;
        setv = hit | (we[c] & wd[4]);
        clrv = ack[c] | (we[c] & wd[5]);
        if (setv)      m_cap[c] = 1'b1;
        else if (clrv) m_cap[c] = 1'b0;
        if (we[c]) begin m_sel[c] = wd[3:0]; m_en[c] = wd[6]; end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = evt;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous model comparison, sampled at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      for (int c = 0; c < NCH; c++) begin
        chk(req[c] == (m_cap[c] & m_en[c]), "R9 model req", req[c], m_cap[c] & m_en[c]);
        chk(rdata[c*CW +: CW] == {1'b0 | m_en[c], 2'b00, m_sel[c]}, "R8 model readback",
            rdata[c*CW +: CW], {m_en[c], 2'b00, m_sel[c]});
      end
    end
  end

  // ---- stimulus helpers (called at a falling edge, return at one)
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int ch, input logic [CW-1:0] d);
    we[ch] = 1'b1; wd = d;
    @(negedge clk);
    we = '0;
  endtask

  task automatic give_ack(input int ch);
    ack[ch] = 1'b1;
    @(negedge clk);
    ack = '0;
  endtask

  task automatic pulse(input int idx);
    evt[idx] = 1'b1; idle(4);
    evt[idx] = 1'b0; idle(4);
  endtask

  // ---- watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---- main sequence
  initial begin
    int rise_codes [5] = '{2, 8, 9, 10, 14};
    int rise_lines [5] = '{1, 6, 7, 8, 9};
    int unused     [7] = '{0, 3, 7, 11, 12, 13, 15};
    int seed = 32'h5eed_0017;
    void'($urandom(seed));

    idle(4);
    rst = 1'b0;
    @(negedge clk);
    chk(req == '0, "R10 reset req", req, 0);
    chk(rdata == '0, "R10 reset readback", rdata, 0);

    // enable ch0 on code 0001 with clear
    wr(0, 7'h61);
    chk(rdata[6:0] == 7'h41, "R8 clr bit reads 0", rdata[6:0], 7'h41);

    // latency R4 / R1 serial receive
    evt[0] = 1'b1; idle(2);
    chk(req[0] == 1'b0, "R4 not yet after 2 edges", req[0], 0);
    idle(1);
    chk(req[0] == 1'b1, "R4 R1 set at third edge", req[0], 1);
    chk(req[1] == 1'b0, "R1 other channel quiet", req[1], 0);
    idle(6);
    chk(req[0] == 1'b1, "R5 capture holds", req[0], 1);
    give_ack(0);
    chk(req[0] == 1'b0, "R5 ack clears", req[0], 0);
    evt[0] = 1'b0; idle(4);
    chk(req[0] == 1'b0, "R3 falling edge ignored on rise code", req[0], 0);

    // R3 falling-edge code 0101
    wr(0, 7'h45);
    evt[4] = 1'b1; idle(4);
    chk(req[0] == 1'b0, "R3 rise ignored on IN-ready", req[0], 0);
    evt[4] = 1'b0; idle(3);
    chk(req[0] == 1'b1, "R3 falling edge captured", req[0], 1);
    wr(0, 7'h66);
    chk(req[0] == 1'b0, "R8 clear removes capture", req[0], 0);
    evt[5] = 1'b1; idle(4); evt[5] = 1'b0; idle(3);
    chk(req[0] == 1'b1, "R3 endpoint 2 IN falling", req[0], 1);
    give_ack(0);

    // R1 rising codes on ch0
    foreach (rise_codes[k]) begin
      wr(0, 7'h60 | CW'(rise_codes[k]));
      evt[rise_lines[k]] = 1'b1; idle(3);
      chk(req[0] == 1'b1, $sformatf("R1 code %0d", rise_codes[k]), req[0], 1);
      evt[rise_lines[k]] = 1'b0; idle(4);
      give_ack(0);
      chk(req[0] == 1'b0, "R5 ack after code test", req[0], 0);
    end

    // R2 unused codes on ch0
    foreach (unused[k]) begin
      wr(0, 7'h60 | CW'(unused[k]));
      evt = '1; idle(4); evt = '0; idle(4);
      chk(req[0] == 1'b0, $sformatf("R2 unused code %0d", unused[k]), req[0], 0);
    end

    // R2 channel 1 table
    wr(1, 7'h61);
    pulse(0);
    chk(req[1] == 1'b0, "R2 ch1 code 0001 unused", req[1], 0);
    wr(1, 7'h62);
    pulse(1);
    chk(req[1] == 1'b0, "R2 ch1 code 0010 unused", req[1], 0);
    wr(1, 7'h64);
    pulse(2);
    chk(req[1] == 1'b0, "R2 ch1 ignores ext int 0", req[1], 0);
    pulse(3);
    chk(req[1] == 1'b1, "R2 ch1 ext int 1", req[1], 1);
    wr(1, 7'h6E);
    pulse(9);
    chk(req[1] == 1'b0, "R2 ch1 ignores serial I/O", req[1], 0);
    pulse(10);
    chk(req[1] == 1'b1, "R2 ch1 timer", req[1], 1);
    wr(1, 7'h60);

    // R7 software trigger
    wr(1, 7'h50);
    chk(req[1] == 1'b1, "R7 trigger sets", req[1], 1);
    chk(rdata[13:7] == 7'h40, "R7 trigger reads 0", rdata[13:7], 7'h40);
    wr(1, 7'h60);
    chk(req[1] == 1'b0, "R8 clear after trigger", req[1], 0);
    wr(1, 7'h70);
    chk(req[1] == 1'b1, "R6 trigger beats clear in one write", req[1], 1);
    wr(1, 7'h60);

    // R6 edge meets capture clear
    wr(0, 7'h61);
    evt[0] = 1'b1; idle(2);
    wr(0, 7'h61);
    chk(req[0] == 1'b1, "R6 edge beats clear", req[0], 1);
    evt[0] = 1'b0; idle(4);
    give_ack(0);

    // R6 edge meets acknowledge
    wr(0, 7'h71);
    evt[0] = 1'b1; idle(2);
    give_ack(0);
    chk(req[0] == 1'b1, "R6 edge beats ack", req[0], 1);
    evt[0] = 1'b0; idle(4);
    give_ack(0);
    chk(req[0] == 1'b0, "R5 ack after collision", req[0], 0);

    // R9 stale capture while disabled
    wr(0, 7'h01);
    pulse(0);
    chk(req[0] == 1'b0, "R9 disabled gives no req", req[0], 0);
    wr(0, 7'h41);
    chk(req[0] == 1'b1, "R9 enable exposes stale", req[0], 1);
    wr(0, 7'h01);
    wr(0, 7'h61);
    chk(req[0] == 1'b0, "R9 enable with clear drops stale", req[0], 0);

    // random phase, judged by the cycle model
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < EW; b++)
        if ($urandom_range(0, 3) == 0) evt[b] = ~evt[b];
      for (int c = 0; c < NCH; c++) begin
        we[c]  = ($urandom_range(0, 7) == 0);
        ack[c] = ($urandom_range(0, 5) == 0);
      end
      wd = CW'($urandom);
      if ($urandom_range(0, 1) == 0) wd[6] = 1'b1;
      @(negedge clk);
    end
    we = '0; ack = '0;
    idle(2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule